// File: doc/BRIEF.md
# Triggered Acquisition Sequencer

This block sits between a 14-bit converter running on a timebase clock and the sample buffer behind it. It decides which converter words are kept. Once armed, it waits for a trigger. The trigger comes from a software strobe or from an asynchronous external line, chosen by configuration. After the trigger it can begin capturing at once, or it can first wait a programmed number of timebase periods. It then keeps one word out of every N timebase cycles until a programmed number of samples has been taken.

The sequence repeats for a programmed number of triggers. Between bursts the block re-arms itself. A done pulse marks the final sample. Each output word carries the converter bits in its upper fourteen bits. When enabled, the two low bits carry two synchronous digital inputs taken on the same edge as the converter word. When not enabled, the two low bits are zero.

The configuration inputs are expected to stay stable while busy is high. A count value of zero is treated as one for the delay, the scan interval, the samples per trigger and the trigger count.

Top module: `acq_sequencer`

## Requirements
- R1: After reset, out_valid, busy and done are all low, and the block is idle until arm is pulsed.
- R2: With cfg_src_ext=1 only ext_trig can start a burst and sw_trig is ignored. With cfg_src_ext=0 only sw_trig can start a burst and ext_trig is ignored.
- R3: ext_trig passes through a two-flop synchronizer and an edge detector. A rising edge sampled at clock edge k acts as a trigger at edge k+2. A line held high gives only one trigger.
- R4: In post mode (cfg_mode_delay=0), a trigger accepted at edge e makes the first captured sample the converter word present at edge e+1. out_valid is high in the cycle after edge e+1.
- R5: In delay mode (cfg_mode_delay=1), a trigger at edge e captures its first sample at edge e+1+D, where D is cfg_delay. D=0 behaves as D=1, and the largest delay is 65535 periods.
- R6: During a burst, one sample is kept every N timebase cycles, where N is cfg_scan_intrv (N=0 behaves as 1). Consecutive out_valid pulses of a burst are exactly N cycles apart.
- R7: Each accepted trigger yields exactly cfg_samples words. After cfg_trig_count accepted triggers the acquisition ends, and between bursts the block waits for a new trigger.
- R8: Triggers that arrive while a delay or capture is in progress are ignored and do not count toward cfg_trig_count.
- R9: out_data[15:2] equals adc_data as it was at the capture edge.
- R10: With cfg_sdi_en=1, out_data[0] holds sdi_in[0] and out_data[1] holds sdi_in[1] from the capture edge. With cfg_sdi_en=0, out_data[1:0] is 2'b00.
- R11: busy goes high on the edge that takes arm in idle. It stays high through waiting, delay and capture, and falls on the edge that registers the final sample. No out_valid occurs while idle.
- R12: done is a one-cycle pulse coinciding with the final out_valid of the last burst, after which the block is idle. An arm pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| arm | input | 1 | One-cycle strobe that starts an acquisition from idle |
| cfg_src_ext | input | 1 | Trigger source: 1 external line, 0 software strobe |
| cfg_mode_delay | input | 1 | Trigger mode: 1 delay, 0 post |
| cfg_delay | input | 16 | Delay in timebase periods (delay mode) |
| cfg_scan_intrv | input | 16 | Scan interval divider N |
| cfg_samples | input | 16 | Samples captured per trigger |
| cfg_trig_count | input | 16 | Number of triggers per acquisition |
| cfg_sdi_en | input | 1 | Pack digital inputs into the low bits |
| sw_trig | input | 1 | Software trigger strobe |
| ext_trig | input | 1 | Asynchronous external trigger line |
| adc_data | input | 14 | Converter word |
| sdi_in | input | 2 | Synchronous digital inputs |
| out_data | output | 16 | Packed sample word |
| out_valid | output | 1 | out_data is a new sample |
| busy | output | 1 | Acquisition in progress |
| done | output | 1 | Final sample pulse |

## Verification
The bench runs a cycle-level reference model alongside the design and goes after the off-by-one edges. A delay or post start that is one edge late would shift every sample and fail the per-cycle data comparison. A delay of zero that wraps to 65536 would hang the run. The bench fires extra triggers in the middle of a delay and in the middle of a capture. A design that counted those triggers would end the acquisition with too few samples, and a design that obeyed them would restart a burst early. An external line held high across a re-arm checks the edge detector: a level-sensitive design would start a second burst with no new edge. Toggling the deselected source, arming while busy, and switching the digital input enable check that these have no effect on the outputs.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_WAIT    = 2'd1,
      ST_DELAY   = 2'd2,
      ST_CAPTURE = 2'd3
   } acq_state_e;

   function automatic logic [15:0] at_least_one(input logic [15:0] v);
      return (v == 16'd0) ? 16'd1 : v;
   endfunction
endpackage

// File: rtl/acq_trig_front.sv
module acq_trig_front #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_ext,
   input  logic sw_trig,
   input  logic ext_trig,
   output logic trig_pulse
);
   localparam int CHAIN_LEN = SYNC_STAGES + 1;

   initial begin
      if (SYNC_STAGES < 2) $error("SYNC_STAGES must be at least 2");
   end

   logic [CHAIN_LEN-1:0] chain_q;

   generate
      for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= ext_trig;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain_q[g] <= 1'b0;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   logic ext_edge;
   assign ext_edge   = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
   assign trig_pulse = sel_ext ? ext_edge : sw_trig;

   // R3: an edge pulse never lasts two cycles
   assert_edge_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_edge |=> !ext_edge);
endmodule

// File: rtl/acq_ctrl.sv
module acq_ctrl
   import acq_seq_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             trig_pulse,
   input  logic             cfg_mode_delay,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_scan_intrv,
   input  logic [CNT_W-1:0] cfg_samples,
   input  logic [CNT_W-1:0] cfg_trig_count,
   output logic             capture_stb,
   output logic             busy,
   output logic             done
);
   initial begin
      if (CNT_W != 16) $error("CNT_W must be 16 to match the count fields");
   end

   acq_state_e       state_q;
   logic [CNT_W-1:0] delay_q;
   logic [CNT_W-1:0] scan_q;
   logic [CNT_W-1:0] samp_q;
   logic [CNT_W-1:0] trem_q;
   logic             done_q;

   logic [CNT_W-1:0] delay_eff, scan_eff, samp_eff, trig_eff;
   assign delay_eff = at_least_one(cfg_delay);
   assign scan_eff  = at_least_one(cfg_scan_intrv);
   assign samp_eff  = at_least_one(cfg_samples);
   assign trig_eff  = at_least_one(cfg_trig_count);

   logic last_samp, last_trig;
   assign capture_stb = (state_q == ST_CAPTURE) && (scan_q == '0);
   assign last_samp   = (samp_q == samp_eff - 1'b1);
   assign last_trig   = (trem_q == {{(CNT_W-1){1'b0}}, 1'b1});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         delay_q <= '0;
         scan_q  <= '0;
         samp_q  <= '0;
         trem_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (arm) begin
                  state_q <= ST_WAIT;
                  trem_q  <= trig_eff;
               end
            end
            ST_WAIT: begin
               if (trig_pulse) begin
                  scan_q <= '0;
                  samp_q <= '0;
                  if (cfg_mode_delay) begin
                     state_q <= ST_DELAY;
                     delay_q <= delay_eff;
                  end else begin
                     state_q <= ST_CAPTURE;
                  end
               end
            end
            ST_DELAY: begin
               if (delay_q <= {{(CNT_W-1){1'b0}}, 1'b1}) state_q <= ST_CAPTURE;
               else                                        delay_q <= delay_q - 1'b1;
            end
            ST_CAPTURE: begin
               if (scan_q == '0) begin
                  scan_q <= scan_eff - 1'b1;
                  if (last_samp) begin
                     samp_q <= '0;
                     if (last_trig) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                     end else begin
                        trem_q  <= trem_q - 1'b1;
                        state_q <= ST_WAIT;
                     end
                  end else begin
                     samp_q <= samp_q + 1'b1;
                  end
               end else begin
                  scan_q <= scan_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state_q != ST_IDLE);
   assign done = done_q;

   // R5: a delay that has run out always leads into capture
   assert_delay_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY && delay_q <= 1) |=> (state_q == ST_CAPTURE));
   // R8: a trigger during a running delay does not disturb it
   assert_ignore_in_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY && delay_q > 1 && trig_pulse) |=> (state_q == ST_DELAY));
   // R12: arm while busy leaves the trigger budget alone
   assert_arm_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && arm && !trig_pulse) |=> $stable(trem_q));
endmodule

// File: rtl/acq_sample_pack.sv
module acq_sample_pack #(
   parameter int ADC_W = 14,
   parameter int SDI_W = 2,
   parameter int OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  logic             sdi_en,
   input  logic [ADC_W-1:0] adc_data,
   input  logic [SDI_W-1:0] sdi_in,
   output logic [OUT_W-1:0] out_data,
   output logic             out_valid
);
   initial begin
      if (OUT_W != ADC_W + SDI_W) $error("OUT_W must equal ADC_W + SDI_W");
   end

   logic [SDI_W-1:0] sdi_gated;

   generate
      for (genvar b = 0; b < SDI_W; b++) begin : g_sdi
         assign sdi_gated[b] = sdi_en & sdi_in[b];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_data  <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= stb;
         if (stb) out_data <= {adc_data, sdi_gated};
      end
   end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
   import acq_seq_pkg::*;
#(
   parameter int ADC_W       = 14,
   parameter int SDI_W       = 2,
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int OUT_W      = ADC_W + SDI_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             cfg_src_ext,
   input  logic             cfg_mode_delay,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [CNT_W-1:0] cfg_scan_intrv,
   input  logic [CNT_W-1:0] cfg_samples,
   input  logic [CNT_W-1:0] cfg_trig_count,
   input  logic             cfg_sdi_en,
   input  logic             sw_trig,
   input  logic             ext_trig,
   input  logic [ADC_W-1:0] adc_data,
   input  logic [SDI_W-1:0] sdi_in,
   output logic [OUT_W-1:0] out_data,
   output logic             out_valid,
   output logic             busy,
   output logic             done
);
   initial begin
      if (ADC_W < 1 || SDI_W < 1) $error("ADC_W and SDI_W must be positive");
   end

   logic trig_pulse;
   logic capture_stb;

   acq_trig_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
      .clk(clk), .rst_n(rst_n), .sel_ext(cfg_src_ext),
      .sw_trig(sw_trig), .ext_trig(ext_trig), .trig_pulse(trig_pulse)
   );

   acq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .arm(arm), .trig_pulse(trig_pulse),
      .cfg_mode_delay(cfg_mode_delay), .cfg_delay(cfg_delay),
      .cfg_scan_intrv(cfg_scan_intrv), .cfg_samples(cfg_samples),
      .cfg_trig_count(cfg_trig_count), .capture_stb(capture_stb),
      .busy(busy), .done(done)
   );

   acq_sample_pack #(.ADC_W(ADC_W), .SDI_W(SDI_W), .OUT_W(OUT_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .stb(capture_stb), .sdi_en(cfg_sdi_en),
      .adc_data(adc_data), .sdi_in(sdi_in),
      .out_data(out_data), .out_valid(out_valid)
   );

   // R9: converter bits land in the upper field
   assert_word_layout_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[OUT_W-1:SDI_W] == $past(adc_data)));
   // R10: low bits follow the enable
   assert_sdi_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[SDI_W-1:0] == ($past(cfg_sdi_en) ? $past(sdi_in) : '0)));
   // R11: no sample appears unless busy was high at the capture edge
   assert_no_idle_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> !out_valid);
   // R12: done marks the final sample and the return to idle
   assert_done_final_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (out_valid && !busy));
endmodule

// File: tb/acq_sequencer_tb.sv
module acq_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        arm = 1'b0;
   logic        cfg_src_ext = 1'b0;
   logic        cfg_mode_delay = 1'b0;
   logic [15:0] cfg_delay = 16'd1;
   logic [15:0] cfg_scan_intrv = 16'd1;
   logic [15:0] cfg_samples = 16'd1;
   logic [15:0] cfg_trig_count = 16'd1;
   logic        cfg_sdi_en = 1'b0;
   logic        sw_trig = 1'b0;
   logic        ext_trig = 1'b0;
   logic [13:0] adc_data = 14'd0;
   logic [1:0]  sdi_in = 2'd0;
   logic [15:0] out_data;
   logic        out_valid, busy, done;

   always #5 clk = ~clk;

   acq_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_src_ext(cfg_src_ext),
      .cfg_mode_delay(cfg_mode_delay), .cfg_delay(cfg_delay),
      .cfg_scan_intrv(cfg_scan_intrv), .cfg_samples(cfg_samples),
      .cfg_trig_count(cfg_trig_count), .cfg_sdi_en(cfg_sdi_en),
      .sw_trig(sw_trig), .ext_trig(ext_trig), .adc_data(adc_data),
      .sdi_in(sdi_in), .out_data(out_data), .out_valid(out_valid),
      .busy(busy), .done(done)
   );

   int errors = 0;
   int checks = 0;
   int vcount = 0;
   string cur_req = "R1";
   bit finished = 1'b0;

   // reference model state
   int  m_st = 0;           // 0 idle, 1 waiting, 2 delaying, 3 capturing
   int  m_trem, m_dcnt, m_sc, m_scnt;
   bit  e1, e2, e3;
   bit  exp_valid = 0, exp_done = 0;
   logic [15:0] exp_data = '0;
   int  last_v_cycle = -1, cyc = 0;

   function automatic int one_min(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   always @(posedge clk) begin
      bit trig;
      cyc++;
      if (!rst_n) begin
         m_st = 0; e1 = 0; e2 = 0; e3 = 0;
         exp_valid = 0; exp_done = 0; exp_data = '0;
      end else begin
         trig = cfg_src_ext ? (e2 && !e3) : sw_trig;
         e3 = e2; e2 = e1; e1 = ext_trig;
         exp_valid = 0; exp_done = 0;
         if (m_st == 0) begin
            if (arm) begin m_st = 1; m_trem = one_min(cfg_trig_count); end
         end else if (m_st == 1) begin
            if (trig) begin
               m_sc = 0; m_scnt = 0;
               if (cfg_mode_delay) begin m_st = 2; m_dcnt = one_min(cfg_delay); end
               else m_st = 3;
            end
         end else if (m_st == 2) begin
            if (m_dcnt <= 1) m_st = 3; else m_dcnt--;
         end else begin
            if (m_sc == 0) begin
               exp_valid = 1;
               exp_data = {adc_data, cfg_sdi_en ? sdi_in : 2'b00};
               m_scnt++;
               m_sc = one_min(cfg_scan_intrv) - 1;
               if (m_scnt == one_min(cfg_samples)) begin
                  m_scnt = 0;
                  if (m_trem == 1) begin m_st = 0; exp_done = 1; end
                  else begin m_trem--; m_st = 1; end
               end
            end else m_sc--;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(out_valid === exp_valid, cur_req, "out_valid", out_valid, exp_valid);
         chk(busy === (m_st != 0), "R11", "busy", busy, m_st != 0);
         chk(done === exp_done, "R12", "done", done, exp_done);
         if (exp_valid) chk(out_data === exp_data, cur_req, "out_data", out_data, exp_data);
         if (out_valid) vcount++;
      end
   end

   // data source: changes every cycle
   initial begin
      forever begin
         @(negedge clk);
         adc_data = adc_data + 14'd1371;
         sdi_in   = sdi_in + 2'd1;
      end
   end

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_arm();
      @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
   endtask

   task automatic pulse_sw();
      @(negedge clk); sw_trig = 1'b1; @(negedge clk); sw_trig = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      while (busy && n < 5000) begin @(negedge clk); n++; end
      cycles(2);
   endtask

   task automatic setup(input bit ext, input bit dly, input int d, input int n,
                        input int s, input int t, input bit sdi);
      cfg_src_ext = ext; cfg_mode_delay = dly; cfg_delay = d[15:0];
      cfg_scan_intrv = n[15:0]; cfg_samples = s[15:0]; cfg_trig_count = t[15:0];
      cfg_sdi_en = sdi; vcount = 0;
   endtask

   task automatic finish_run();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      int n;
      n = 0;
      while (n < 100000) begin @(posedge clk); n++; end
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected=<100000", n);
         finish_run();
      end
   end

   initial begin
      cycles(3);
      // R1: reset values
      chk(!out_valid && !busy && !done, "R1", "reset outputs",
          {out_valid, busy, done}, 0);
      @(negedge clk); rst_n = 1'b1;
      cycles(4);
      chk(!busy, "R1", "idle without arm", busy, 0);

      // R4 R9: post mode, every cycle
      cur_req = "R4";
      setup(0, 0, 1, 1, 4, 1, 0);
      pulse_arm(); cycles(3); pulse_sw(); wait_idle();
      chk(vcount == 4, "R7", "post samples", vcount, 4);

      // R10: digital inputs packed, then cleared
      cur_req = "R10";
      setup(0, 0, 1, 1, 5, 1, 1);
      pulse_arm(); pulse_sw(); wait_idle();
      chk(vcount == 5, "R10", "sdi samples", vcount, 5);
      setup(0, 0, 1, 2, 3, 1, 0);
      pulse_arm(); pulse_sw(); wait_idle();

      // R5: delay mode, D=5 and D=0
      cur_req = "R5";
      setup(0, 1, 5, 1, 3, 1, 0);
      pulse_arm(); pulse_sw(); wait_idle();
      chk(vcount == 3, "R5", "delay samples", vcount, 3);
      setup(0, 1, 0, 1, 2, 1, 1);
      pulse_arm(); pulse_sw(); wait_idle();

      // R6: scan interval 3
      cur_req = "R6";
      setup(0, 0, 1, 3, 4, 1, 1);
      pulse_arm(); pulse_sw(); wait_idle();
      chk(vcount == 4, "R6", "divided samples", vcount, 4);

      // R7 R8: re-trigger with stray triggers during delay and capture
      cur_req = "R8";
      setup(0, 1, 4, 2, 3, 3, 0);
      pulse_arm();
      for (int k = 0; k < 3; k++) begin
         pulse_sw(); pulse_sw(); cycles(3); pulse_sw(); cycles(12);
      end
      wait_idle();
      chk(vcount == 9, "R8", "stray triggers not counted", vcount, 9);

      // R2: deselected sources have no effect
      cur_req = "R2";
      setup(1, 0, 1, 1, 2, 1, 0);
      pulse_arm(); pulse_sw(); cycles(8);
      chk(busy && vcount == 0, "R2", "sw ignored in ext mode", vcount, 0);
      @(negedge clk); ext_trig = 1'b1; cycles(3); ext_trig = 1'b0;
      wait_idle();
      chk(vcount == 2, "R2", "ext trigger accepted", vcount, 2);
      setup(0, 0, 1, 1, 2, 1, 0);
      pulse_arm(); ext_trig = 1'b1; cycles(4); ext_trig = 1'b0; cycles(4);
      chk(busy && vcount == 0, "R2", "ext ignored in sw mode", vcount, 0);
      pulse_sw(); wait_idle();

      // R3: held level gives one trigger; new edge gives another
      cur_req = "R3";
      setup(1, 0, 1, 1, 2, 2, 1);
      pulse_arm(); @(negedge clk); ext_trig = 1'b1; cycles(20);
      chk(busy && vcount == 2, "R3", "held level single trigger", vcount, 2);
      ext_trig = 1'b0; cycles(3); ext_trig = 1'b1; cycles(3); ext_trig = 1'b0;
      wait_idle();
      chk(vcount == 4, "R3", "second edge trigger", vcount, 4);

      // R12: arm while busy ignored, done ends run
      cur_req = "R12";
      setup(0, 0, 1, 1, 2, 2, 0);
      pulse_arm(); cycles(2); pulse_arm(); pulse_sw(); cycles(5); pulse_sw();
      wait_idle();
      chk(vcount == 2 * 2 && !busy, "R12", "arm while busy", vcount, 4);

      cycles(4);
      finish_run();
   end
endmodule